// File: doc/BRIEF.md
# Successive-Approximation ADC Scan Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. It holds the approximation register and drives a trial code onto the converter's resistor-ladder DAC. On each conversion-clock tick it reads the analog comparator and either keeps or drops the trial bit, working from the most significant bit down. Before the first trial, each conversion holds the input multiplexer on its channel for two conversion-clock ticks so the sample stage can settle. The comparator, the ladder and the sample stage are outside the block.

Software sets up the block with a single write. That write carries the scan mode, a channel number, the sweep group size, the resolution, the clock divide code, the interrupt enable and the start bit. The block then runs one of five scan modes over eight analog inputs and stores each finished code in that input's own result register, which can be read back at any time. One-shot and single-sweep operations clear the start bit when they finish and can pulse an end-of-conversion interrupt. The repeating modes keep running until software writes the start bit to zero. Such a write aborts any conversion in progress.

Top module: `sar_scan_seq`

## Requirements
- R1: With `cfg_res10_i`=1 a conversion makes 10 trials and stores the full 10-bit code. With `cfg_res10_i`=0 it makes 8 trials on DAC bits 9..2 only: DAC bits 1:0 stay 0, and the stored result is the upper 8 bits of the code, right-justified, with result bits 9:8 equal to 0.
- R2: Divide codes 0,1,2,3,4,5 select conversion-clock ratios 1,2,3,4,6,12, and codes 6 and 7 select 12. A conversion lasts (trials+2) conversion ticks, and `sample_o` is high during the first 2 of them. A one-shot interrupt appears exactly (trials+2)*ratio clock edges after the write edge.
- R3: Mode 0 (one-shot) converts channel `cfg_chan_i` once, stores the result, clears the start bit and, when enabled, pulses `eoc_irq_o` high for exactly one cycle.
- R4: Mode 1 (repeat) converts channel `cfg_chan_i` continuously. Its result register follows the input, `start_o` stays 1 and no interrupt is raised.
- R5: Mode 2 (single sweep) converts channels 0 up to the last group channel once each, in ascending order. It then clears the start bit and raises one interrupt when enabled.
- R6: The group field values 0,1,2,3 select 2,4,6,8 channels, always starting at channel 0. In sweep modes `mux_sel_o` never leaves the group.
- R7: Mode 3 (repeat sweep) cycles through the group channels in ascending order without end, raising no interrupt.
- R8: Mode 4 (priority repeat sweep) alternates channel `cfg_chan_i` with the group channels: P,0,P,1,…,P,last,P,0,…. It raises no interrupt.
- R9: A write with `cfg_start_i`=0 stops at once. No result is stored, no interrupt follows, and `dac_code_o` returns to 0 with `sample_o` low.
- R10: There are eight result registers, which reset to 0 and can be read at any time through `rd_sel_i`. A conversion writes only the register of its own channel.
- R11: With `cfg_ien_i`=0 an operation that would raise an interrupt still completes and clears its start bit, but `eoc_irq_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Control write strobe; all control fields are captured together |
| cfg_mode_i | input | 3 | Scan mode: 0 one-shot, 1 repeat, 2 single sweep, 3 repeat sweep, 4 priority repeat sweep |
| cfg_chan_i | input | 3 | Channel for modes 0 and 1, priority channel for mode 4 |
| cfg_grp_i | input | 2 | Sweep group size code (2,4,6,8 channels) |
| cfg_res10_i | input | 1 | 1 = 10-bit, 0 = 8-bit resolution |
| cfg_div_i | input | 3 | Conversion clock divide code |
| cfg_ien_i | input | 1 | End-of-conversion interrupt enable |
| cfg_start_i | input | 1 | Start bit value written |
| start_o | output | 1 | Current start bit (running) |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the DAC code |
| dac_code_o | output | 10 | Trial code driven to the ladder DAC |
| mux_sel_o | output | 3 | Analog input multiplexer select |
| sample_o | output | 1 | High while the sample stage is tracking |
| rd_sel_i | input | 3 | Result register read select |
| rd_data_o | output | 10 | Selected result register |
| eoc_irq_o | output | 1 | End-of-conversion interrupt pulse |

## Verification
The hardest order to reach from the ports is the mode-4 interleave. It only shows across many conversions, and the priority channel can also be a group member. The bench records `mux_sel_o` on every rising edge of `sample_o` and compares the log with the P,0,P,1,… pattern over a full wrap of a 4-channel group. The abort case needs a write to land inside a conversion. The bench uses the slowest divider so that a fixed delay lands well inside the approximation phase, then watches the result register and the interrupt for a long quiet window.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        MODE_ONCE      = 3'd0,
        MODE_REPEAT    = 3'd1,
        MODE_SWEEP     = 3'd2,
        MODE_RSWEEP    = 3'd3,
        MODE_RSWEEP_PR = 3'd4
    } scan_mode_e;

    typedef struct packed {
        logic [2:0] mode;
        logic [2:0] chan;
        logic [1:0] grp;
        logic       res10;
        logic [2:0] div;
        logic       ien;
    } scan_cfg_t;

    // conversion clock ratio selected by the divide code
    function automatic int unsigned div_ratio(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 3;
            3'd3:    return 4;
            3'd4:    return 6;
            default: return 12;
        endcase
    endfunction

    // group size in channels, in quarters of the channel count
    function automatic int unsigned grp_size(input logic [1:0] g, input int unsigned nch);
        return (int'(g) + 1) * nch / 4;
    endfunction

endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
    parameter int CW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic [2:0] div_i,
    output logic       tick_o
);
    import sar_pkg::*;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim    = CW'(div_ratio(div_i) - 1);
        tick_o = run_i && !clr_i && (cnt_q == lim);
        if (!run_i || clr_i || tick_o) cnt_d = '0;
        else                           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
    parameter int RES_HI = 10,
    parameter int RES_LO = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              clr_i,
    input  logic              tick_i,
    input  logic              res10_i,
    input  logic              cmp_i,
    output logic [RES_HI-1:0] dac_code_o,
    output logic              sampling_o,
    output logic              done_o,
    output logic [RES_HI-1:0] result_o
);
    localparam int SW    = $clog2(RES_HI + 3);
    localparam int SHIFT = RES_HI - RES_LO;

    typedef struct packed {
        logic [SW-1:0]     step;
        logic [RES_HI-1:0] sar;
    } appr_t;

    appr_t             st_d, st_q;
    logic [SW-1:0]     last;
    logic              comparing;
    logic [RES_HI-1:0] trial;
    logic [RES_HI-1:0] kept;

    always_comb begin
        // steps 0 and 1 sample, then one step per trial bit
        last      = res10_i ? SW'(RES_HI + 1) : SW'(RES_LO + 1);
        comparing = (st_q.step >= SW'(2));
        trial     = '0;
        if (comparing)
            trial = RES_HI'(1) << (RES_HI + 1 - int'(st_q.step));
        dac_code_o = st_q.sar | trial;
        kept       = cmp_i ? dac_code_o : st_q.sar;
        sampling_o = run_i && !comparing;
        done_o     = run_i && !clr_i && tick_i && (st_q.step == last);
        result_o   = res10_i ? kept : (kept >> SHIFT);

        st_d = st_q;
        if (!run_i || clr_i) begin
            st_d = '0;
        end else if (tick_i) begin
            if (st_q.step == last) begin
                st_d = '0;
            end else begin
                st_d.step = st_q.step + 1'b1;
                st_d.sar  = comparing ? kept : st_q.sar;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
    parameter int NCH = 8,
    parameter int W   = 10,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we_i,
    input  logic [CHW-1:0] wsel_i,
    input  logic [W-1:0]   wdata_i,
    input  logic [CHW-1:0] rsel_i,
    output logic [W-1:0]   rdata_o
);
    logic [W-1:0] bank [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_reg
        logic [W-1:0] r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (we_i && (wsel_i == CHW'(g))) r_d = wdata_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= r_d;
        end

        assign bank[g] = r_q;
    end

    assign rdata_o = bank[rsel_i];

endmodule

// File: rtl/sar_scan_seq.sv
module sar_scan_seq #(
    parameter int NCH    = 8,
    parameter int RES_HI = 10,
    parameter int RES_LO = 8,
    localparam int CHW   = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [2:0]        cfg_mode_i,
    input  logic [CHW-1:0]    cfg_chan_i,
    input  logic [1:0]        cfg_grp_i,
    input  logic              cfg_res10_i,
    input  logic [2:0]        cfg_div_i,
    input  logic              cfg_ien_i,
    input  logic              cfg_start_i,
    output logic              start_o,
    input  logic              cmp_i,
    output logic [RES_HI-1:0] dac_code_o,
    output logic [CHW-1:0]    mux_sel_o,
    output logic              sample_o,
    input  logic [CHW-1:0]    rd_sel_i,
    output logic [RES_HI-1:0] rd_data_o,
    output logic              eoc_irq_o
);
    import sar_pkg::*;

    typedef struct packed {
        scan_cfg_t      cfg;
        logic           start;
        logic [CHW-1:0] chan;
        logic [CHW-1:0] scan;
        logic           pri_turn;
        logic           irq;
    } seq_t;

    seq_t              st_d, st_q;
    logic              tick;
    logic              done;
    logic [RES_HI-1:0] result;
    logic [CHW-1:0]    grp_last;

    sar_clkdiv #(.CW(4)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q.start),
        .clr_i  (cfg_wr_i),
        .div_i  (st_q.cfg.div),
        .tick_o (tick)
    );

    sar_approx #(.RES_HI(RES_HI), .RES_LO(RES_LO)) u_appr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (st_q.start),
        .clr_i      (cfg_wr_i),
        .tick_i     (tick),
        .res10_i    (st_q.cfg.res10),
        .cmp_i      (cmp_i),
        .dac_code_o (dac_code_o),
        .sampling_o (sample_o),
        .done_o     (done),
        .result_o   (result)
    );

    sar_result_bank #(.NCH(NCH), .W(RES_HI)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (done),
        .wsel_i  (st_q.chan),
        .wdata_i (result),
        .rsel_i  (rd_sel_i),
        .rdata_o (rd_data_o)
    );

    always_comb begin
        grp_last = CHW'(grp_size(st_q.cfg.grp, NCH) - 1);
        st_d     = st_q;
        st_d.irq = 1'b0;

        if (cfg_wr_i) begin
            st_d.cfg      = '{mode: cfg_mode_i, chan: cfg_chan_i, grp: cfg_grp_i,
                              res10: cfg_res10_i, div: cfg_div_i, ien: cfg_ien_i};
            st_d.start    = cfg_start_i;
            st_d.scan     = '0;
            st_d.pri_turn = 1'b1;
            if (cfg_mode_i == MODE_SWEEP || cfg_mode_i == MODE_RSWEEP) st_d.chan = '0;
            else                                                       st_d.chan = cfg_chan_i;
        end else if (done) begin
            case (st_q.cfg.mode)
                MODE_REPEAT: ;
                MODE_SWEEP: begin
                    if (st_q.chan == grp_last) begin
                        st_d.start = 1'b0;
                        st_d.irq   = st_q.cfg.ien;
                    end else begin
                        st_d.chan = st_q.chan + 1'b1;
                    end
                end
                MODE_RSWEEP: begin
                    st_d.chan = (st_q.chan == grp_last) ? '0 : st_q.chan + 1'b1;
                end
                MODE_RSWEEP_PR: begin
                    if (st_q.pri_turn) begin
                        st_d.chan     = st_q.scan;
                        st_d.pri_turn = 1'b0;
                    end else begin
                        st_d.chan     = st_q.cfg.chan;
                        st_d.pri_turn = 1'b1;
                        st_d.scan     = (st_q.scan == grp_last) ? '0 : st_q.scan + 1'b1;
                    end
                end
                default: begin
                    st_d.start = 1'b0;
                    st_d.irq   = st_q.cfg.ien;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o   = st_q.start;
    assign mux_sel_o = st_q.chan;
    assign eoc_irq_o = st_q.irq;

endmodule

// File: rtl/sar_scan_seq_chk.sv
module sar_scan_seq_chk #(
    parameter int NCH    = 8,
    parameter int RES_HI = 10,
    parameter int RES_LO = 8,
    localparam int CHW   = $clog2(NCH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_o,
    input logic              eoc_irq_o,
    input logic              sample_o,
    input logic [RES_HI-1:0] dac_code_o,
    input logic [CHW-1:0]    mux_sel_o,
    input logic [2:0]        mode,
    input logic [1:0]        grp,
    input logic              res10
);
    logic [CHW:0] grp_top;
    assign grp_top = (CHW+1)'((int'(grp) + 1) * NCH / 4 - 1);

    // R1: in 8-bit mode the low DAC bits are never tried
    a_r1_low_bits_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !res10 |-> (dac_code_o[RES_HI-RES_LO-1:0] == '0));

    // R9: an idle block drives no trial code and does not sample
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !start_o |-> (dac_code_o == '0 && !sample_o));

    // R3: the interrupt comes only with the end of a run
    a_r3_irq_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq_o |-> !start_o);

    // R3: the interrupt is a single-cycle pulse
    a_r3_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq_o |=> !eoc_irq_o);

    // R4, R7, R8: the repeating modes never interrupt
    a_r4_repeat_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && (mode == 3'd1 || mode == 3'd3 || mode == 3'd4)) |=> !eoc_irq_o);

    // R6: plain sweeps stay inside the group
    a_r6_mux_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && (mode == 3'd2 || mode == 3'd3)) |-> ({1'b0, mux_sel_o} <= grp_top));

endmodule

bind sar_scan_seq sar_scan_seq_chk #(.NCH(NCH), .RES_HI(RES_HI), .RES_LO(RES_LO)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_o    (start_o),
    .eoc_irq_o  (eoc_irq_o),
    .sample_o   (sample_o),
    .dac_code_o (dac_code_o),
    .mux_sel_o  (mux_sel_o),
    .mode       (st_q.cfg.mode),
    .grp        (st_q.cfg.grp),
    .res10      (st_q.cfg.res10)
);

// File: tb/sar_scan_seq_tb.sv
module sar_scan_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_mode = '0;
    logic [2:0] cfg_chan = '0;
    logic [1:0] cfg_grp = '0;
    logic       cfg_res10 = 1'b0;
    logic [2:0] cfg_div = '0;
    logic       cfg_ien = 1'b0;
    logic       cfg_start = 1'b0;
    logic       start_o;
    logic       cmp;
    logic [9:0] dac_code;
    logic [2:0] mux_sel;
    logic       sample;
    logic [2:0] rd_sel = '0;
    logic [9:0] rd_data;
    logic       eoc_irq;

    logic [9:0] vin [8];
    logic [9:0] exp_res [8];
    int checks = 0;
    int fails = 0;
    int irq_cnt = 0;
    int seq_n = 0;
    logic [2:0] seq_log [64];
    logic prev_sample = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    // comparator model: high when the input is at or above the trial code
    assign cmp = (vin[mux_sel] >= dac_code);

    sar_scan_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_mode_i(cfg_mode),
        .cfg_chan_i(cfg_chan), .cfg_grp_i(cfg_grp), .cfg_res10_i(cfg_res10),
        .cfg_div_i(cfg_div), .cfg_ien_i(cfg_ien), .cfg_start_i(cfg_start),
        .start_o(start_o), .cmp_i(cmp), .dac_code_o(dac_code), .mux_sel_o(mux_sel),
        .sample_o(sample), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .eoc_irq_o(eoc_irq)
    );

    always @(negedge clk) begin
        if (eoc_irq) irq_cnt++;
        if (sample && !prev_sample && seq_n < 64) begin
            seq_log[seq_n] = mux_sel;
            seq_n++;
        end
        prev_sample = sample;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int mode, input int chan, input int grp, input bit r10,
                             input int dv, input bit ien, input bit st);
        @(negedge clk);
        cfg_mode = 3'(mode); cfg_chan = 3'(chan); cfg_grp = 2'(grp);
        cfg_res10 = r10; cfg_div = 3'(dv); cfg_ien = ien; cfg_start = st;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit && start_o; i++) @(negedge clk);
    endtask

    task automatic read_chk(input int ch, input string req);
        @(negedge clk);
        rd_sel = 3'(ch);
        #1;
        check(rd_data == exp_res[ch], req, rd_data, exp_res[ch]);
    endtask

    function automatic int ratio_of(input int code);
        case (code)
            0: return 1; 1: return 2; 2: return 3; 3: return 4; 4: return 6;
            default: return 12;
        endcase
    endfunction

    // R2 R3: one-shot timing from the write edge to the interrupt
    task automatic t_oneshot_timing(input int ch, input bit r10, input int dv);
        int n = 0;
        int expk = ((r10 ? 10 : 8) + 2) * ratio_of(dv);
        int samp_cycles = 0;
        @(negedge clk);
        cfg_mode = 3'd0; cfg_chan = 3'(ch); cfg_grp = 2'd0; cfg_res10 = r10;
        cfg_div = 3'(dv); cfg_ien = 1'b1; cfg_start = 1'b1; cfg_wr = 1'b1;
        while (n < 400) begin
            @(negedge clk);
            cfg_wr = 1'b0;
            n++;
            if (sample) samp_cycles++;
            if (eoc_irq) break;
        end
        check(n - 1 == expk, "R2 conversion length", n - 1, expk);
        check(samp_cycles == 2 * ratio_of(dv), "R2 sample window", samp_cycles, 2 * ratio_of(dv));
        check(!start_o, "R3 start cleared", start_o, 0);
        exp_res[ch] = r10 ? vin[ch] : 10'(vin[ch] >> 2);
        read_chk(ch, r10 ? "R1 10-bit result" : "R1 8-bit result");
    endtask

    task automatic t_reset;
        check(!start_o && !eoc_irq && dac_code == 0 && !sample, "R9 reset idle", dac_code, 0);
        for (int c = 0; c < 8; c++) read_chk(c, "R10 reset result");
    endtask

    task automatic t_no_ien;
        int ic = irq_cnt;
        vin[4] = 10'h2E7;
        write_cfg(0, 4, 0, 1, 1, 0, 1);
        wait_idle(200);
        repeat (3) @(negedge clk);
        check(irq_cnt == ic, "R11 irq suppressed", irq_cnt - ic, 0);
        check(!start_o, "R11 start cleared", start_o, 0);
        exp_res[4] = vin[4];
        read_chk(4, "R11 result stored");
    endtask

    task automatic t_single_sweep(input int grp, input bit r10);
        int ic = irq_cnt;
        int ng = (grp + 1) * 2;
        seq_n = 0;
        write_cfg(2, 7, grp, r10, 0, 1, 1);
        wait_idle(2000);
        repeat (3) @(negedge clk);
        check(seq_n == ng, "R6 sweep length", seq_n, ng);
        for (int i = 0; i < ng && i < seq_n; i++)
            check(seq_log[i] == 3'(i), "R5 sweep order", seq_log[i], i);
        check(irq_cnt == ic + 1, "R5 one irq", irq_cnt - ic, 1);
        for (int c = 0; c < ng; c++) exp_res[c] = r10 ? vin[c] : 10'(vin[c] >> 2);
        for (int c = 0; c < 8; c++) read_chk(c, "R10 sweep results");
    endtask

    task automatic t_repeat;
        int ic = irq_cnt;
        vin[3] = 10'h155;
        write_cfg(1, 3, 0, 1, 0, 1, 1);
        repeat (40) @(negedge clk);
        exp_res[3] = 10'h155;
        read_chk(3, "R4 repeat first");
        vin[3] = 10'h3C1;
        repeat (40) @(negedge clk);
        exp_res[3] = 10'h3C1;
        read_chk(3, "R4 repeat follows input");
        check(start_o, "R4 start held", start_o, 1);
        check(irq_cnt == ic, "R4 no irq", irq_cnt - ic, 0);
        write_cfg(1, 3, 0, 1, 0, 1, 0);
        @(negedge clk);
        check(!start_o && dac_code == 0, "R9 stop repeat", dac_code, 0);
    endtask

    task automatic t_rsweep(input int mode, input int grp, input int pri, input int nlog);
        int ic = irq_cnt;
        int ng = (grp + 1) * 2;
        seq_n = 0;
        write_cfg(mode, pri, grp, 0, 0, 1, 1);
        for (int i = 0; i < 3000 && seq_n < nlog; i++) @(negedge clk);
        write_cfg(mode, pri, grp, 0, 0, 1, 0);
        check(seq_n >= nlog, "R7 progress", seq_n, nlog);
        for (int i = 0; i < nlog; i++) begin
            int e = (mode == 3) ? (i % ng) : ((i % 2 == 0) ? pri : ((i / 2) % ng));
            check(seq_log[i] == 3'(e), mode == 3 ? "R7 cyclic order" : "R8 priority order",
                  seq_log[i], e);
        end
        check(irq_cnt == ic, mode == 3 ? "R7 no irq" : "R8 no irq", irq_cnt - ic, 0);
        for (int c = 0; c < ng; c++) exp_res[c] = 10'(vin[c] >> 2);
        if (mode == 4) exp_res[pri] = 10'(vin[pri] >> 2);
    endtask

    task automatic t_abort;
        int ic = irq_cnt;
        vin[7] = 10'h1F0;
        write_cfg(0, 7, 0, 1, 5, 1, 1);
        repeat (60) @(negedge clk);
        write_cfg(0, 7, 0, 1, 5, 1, 0);
        check(!start_o && dac_code == 0 && !sample, "R9 abort idle", dac_code, 0);
        repeat (200) @(negedge clk);
        check(irq_cnt == ic, "R9 no irq after abort", irq_cnt - ic, 0);
        read_chk(7, "R9 result untouched");
    endtask

    initial begin
        for (int c = 0; c < 8; c++) begin
            vin[c] = 10'(37 + c * 121);
            exp_res[c] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot_timing(5, 1, 0);
        t_oneshot_timing(2, 0, 2);
        for (int d = 0; d < 8; d++) t_oneshot_timing(1, 0, d);
        t_no_ien();
        t_single_sweep(1, 1);
        t_single_sweep(2, 0);
        t_repeat();
        t_rsweep(3, 0, 0, 6);
        t_rsweep(3, 3, 0, 10);
        t_rsweep(4, 1, 6, 10);
        t_abort();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule